// File: doc/BRIEF.md
# Multi-Channel Summation Output Formatter

This block merges several signed channel samples into a single converter word. On each cycle where the shared input strobe is high, it adds the channel samples at a width that cannot overflow. It then reduces the total to the output width, applies the overrange policy and codes the result for the converter. The output word and its strobe come from registers, one clock after the inputs.

Two control bits sit in a small register reached through a write port. The first bit picks the overrange policy: saturate to full scale, or wrap by keeping only the low bits. The second bit picks the output coding: two's complement, or offset binary. Offset binary is made by inverting the most significant bit of the final two's-complement word, after the overrange step.

With the default parameters there are four channels of 18 bits each and a 16-bit output. The output is bits 17:2 of the 20-bit sum, which is the sum taken at 18-bit alignment.

Top module: `sumfmt_top`

## Requirements
- R1: For a sum inside the 18-bit signed range, out_data is bits 17:2 of the sum of the channels. Channel i occupies in_data bits [18i+17:18i] as a signed value.
- R2: When control bit 0 is 1 and the sum exceeds +131071, the pre-coding word is 0x7FFF. When the sum is below -131072, the pre-coding word is 0x8000.
- R3: When control bit 0 is 0 and the sum is out of range, the pre-coding word is bits 17:2 of the 20-bit sum, so the value wraps.
- R4: When control bit 1 is 0, out_data equals the pre-coding word, which is two's complement.
- R5: When control bit 1 is 1, out_data equals the pre-coding word with bit 15 inverted, which is offset binary.
- R6: out_valid equals in_valid delayed by one clock. out_data updates in the same cycle.
- R7: While in_valid is low, out_data holds its last value.
- R8: A write with cfg_we high to address 0 loads control bits [1:0] from cfg_wdata[1:0]. Writes to any other address leave the control bits unchanged.
- R9: A new control value applies to samples captured on clock edges after the write edge. A sample captured on the write edge uses the old value.
- R10: Reset clears both control bits, selecting wrap and two's complement. It also drives out_valid and out_data to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_we | input | 1 | Control write strobe |
| cfg_addr | input | 4 | Control write address (control register at 0) |
| cfg_wdata | input | 8 | Control write data; bit 0 selects clip, bit 1 selects offset binary |
| in_valid | input | 1 | Shared strobe for all channel samples |
| in_data | input | 72 | Four packed signed 18-bit channel samples, channel 0 lowest |
| out_valid | output | 1 | Output word strobe |
| out_data | output | 16 | Formatted output word |

## Verification
Any fault in the adder chain, the overrange detector or the coding stage shows up in out_data one cycle after the offending sample. The sweep crosses in-range sums, sums just past both rails and sums far past them, in all four modes, so such a fault is caught at once. A control register that loads at the wrong address or on the wrong edge appears as a wrong mode on the first sample after the write. A broken hold path shows as a changed word during a cycle with no strobe.

// File: rtl/sumfmt_pkg.sv
package sumfmt_pkg;
  localparam int CLIP_BIT = 0;
  localparam int OBIN_BIT = 1;

  typedef struct packed {
    logic obin;
    logic clip;
  } fmt_ctrl_t;
endpackage

// File: rtl/sumfmt_ctrl_reg.sv
module sumfmt_ctrl_reg
  import sumfmt_pkg::*;
#(
  parameter int ADDR_W    = 4,
  parameter int DATA_W    = 8,
  parameter int CTRL_ADDR = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output fmt_ctrl_t         ctrl
);
  localparam logic [ADDR_W-1:0] SEL = ADDR_W'(CTRL_ADDR);

  fmt_ctrl_t ctrl_d, ctrl_q;
  logic      hit;

  always_comb begin
    hit    = we && (addr == SEL);
    ctrl_d = ctrl_q;
    if (hit) begin
      ctrl_d.clip = wdata[CLIP_BIT];
      ctrl_d.obin = wdata[OBIN_BIT];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
    end else if (hit) begin
      ctrl_q <= ctrl_d;
    end
  end

  assign ctrl = ctrl_q;
endmodule

// File: rtl/sumfmt_adder.sv
module sumfmt_adder #(
  parameter int N_CH = 4,
  parameter int IN_W = 18,
  localparam int SUM_W = IN_W + $clog2(N_CH)
) (
  input  logic [N_CH*IN_W-1:0]    samples,
  output logic signed [SUM_W-1:0] total
);
  localparam int EXT = SUM_W - IN_W;

  logic signed [SUM_W-1:0] chain [N_CH+1];

  assign chain[0] = '0;

  for (genvar i = 0; i < N_CH; i++) begin : g_acc
    logic [IN_W-1:0] lane;
    assign lane         = samples[i*IN_W +: IN_W];
    assign chain[i + 1] = chain[i] + signed'({{EXT{lane[IN_W-1]}}, lane});
  end

  assign total = chain[N_CH];
endmodule

// File: rtl/sumfmt_shape.sv
module sumfmt_shape #(
  parameter int IN_W  = 18,
  parameter int SUM_W = 20,
  parameter int OUT_W = 16
) (
  input  logic signed [SUM_W-1:0] total,
  input  logic                    clip_en,
  input  logic                    obin_en,
  output logic [OUT_W-1:0]        word
);
  localparam int               HEAD   = SUM_W - IN_W + 1;
  localparam logic [OUT_W-1:0] POS_FS = {1'b0, {(OUT_W-1){1'b1}}};
  localparam logic [OUT_W-1:0] NEG_FS = {1'b1, {(OUT_W-1){1'b0}}};

  logic [HEAD-1:0]  head;
  logic             over;
  logic [OUT_W-1:0] trunc;
  logic [OUT_W-1:0] ranged;

  always_comb begin
    head  = total[SUM_W-1:IN_W-1];
    over  = !((&head) || !(|head));
    trunc = total[IN_W-1 -: OUT_W];
    if (clip_en && over) begin
      ranged = total[SUM_W-1] ? NEG_FS : POS_FS;
    end else begin
      ranged = trunc;
    end
    word = ranged;
    if (obin_en) begin
      word[OUT_W-1] = ~ranged[OUT_W-1];
    end
  end
endmodule

// File: rtl/sumfmt_top.sv
module sumfmt_top
  import sumfmt_pkg::*;
#(
  parameter int N_CH      = 4,
  parameter int IN_W      = 18,
  parameter int OUT_W     = 16,
  parameter int ADDR_W    = 4,
  parameter int DATA_W    = 8,
  parameter int CTRL_ADDR = 0
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cfg_we,
  input  logic [ADDR_W-1:0]    cfg_addr,
  input  logic [DATA_W-1:0]    cfg_wdata,
  input  logic                 in_valid,
  input  logic [N_CH*IN_W-1:0] in_data,
  output logic                 out_valid,
  output logic [OUT_W-1:0]     out_data
);
  localparam int SUM_W = IN_W + $clog2(N_CH);

  logic [1:0]              rst_pipe;
  logic                    rst_sync_n;
  fmt_ctrl_t               ctrl;
  logic                    ctrl_clip;
  logic                    ctrl_obin;
  logic signed [SUM_W-1:0] total;
  logic [OUT_W-1:0]        word;
  logic [OUT_W-1:0]        data_d, data_q;
  logic                    vld_d, vld_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe <= 2'b00;
    end else begin
      rst_pipe <= {rst_pipe[0], 1'b1};
    end
  end
  assign rst_sync_n = rst_pipe[1];

  sumfmt_ctrl_reg #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CTRL_ADDR(CTRL_ADDR)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_sync_n), .we(cfg_we), .addr(cfg_addr),
    .wdata(cfg_wdata), .ctrl(ctrl)
  );

  assign ctrl_clip = ctrl.clip;
  assign ctrl_obin = ctrl.obin;

  sumfmt_adder #(.N_CH(N_CH), .IN_W(IN_W)) u_add (
    .samples(in_data), .total(total)
  );

  sumfmt_shape #(.IN_W(IN_W), .SUM_W(SUM_W), .OUT_W(OUT_W)) u_shape (
    .total(total), .clip_en(ctrl_clip), .obin_en(ctrl_obin), .word(word)
  );

  always_comb begin
    vld_d  = in_valid;
    data_d = in_valid ? word : data_q;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      vld_q  <= 1'b0;
      data_q <= '0;
    end else begin
      vld_q <= vld_d;
      if (in_valid) begin
        data_q <= data_d;
      end
    end
  end

  assign out_valid = vld_q;
  assign out_data  = data_q;
endmodule

// File: rtl/sumfmt_top_chk.sv
module sumfmt_top_chk #(
  parameter int N_CH  = 4,
  parameter int IN_W  = 18,
  parameter int OUT_W = 16
) (
  input logic                 clk,
  input logic                 rst_sync_n,
  input logic                 in_valid,
  input logic [N_CH*IN_W-1:0] in_data,
  input logic                 ctrl_clip,
  input logic                 ctrl_obin,
  input logic                 out_valid,
  input logic [OUT_W-1:0]     out_data
);
  localparam int SUM_W = IN_W + $clog2(N_CH);
  localparam int EXT   = SUM_W - IN_W;
  localparam logic signed [SUM_W-1:0] MAXV = SUM_W'((1 <<< (IN_W - 1)) - 1);
  localparam logic signed [SUM_W-1:0] MINV = ~MAXV;

  logic signed [SUM_W-1:0] acc;
  logic signed [SUM_W-1:0] acc_q;

  always_comb begin
    acc = '0;
    for (int i = 0; i < N_CH; i++) begin
      acc = acc + signed'({{EXT{in_data[i*IN_W+IN_W-1]}}, in_data[i*IN_W +: IN_W]});
    end
  end

  always_ff @(posedge clk) begin
    acc_q <= acc;
  end

  p_reset_quiet_r10: assert property (@(posedge clk)
    !rst_sync_n |-> (!out_valid && out_data == '0));

  p_valid_delay_r6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $past(rst_sync_n) |-> (out_valid == $past(in_valid)));

  p_hold_idle_r7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ($past(rst_sync_n) && !$past(in_valid)) |-> $stable(out_data));

  p_clip_pos_r2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ($past(rst_sync_n) && $past(in_valid) && $past(ctrl_clip) && !$past(ctrl_obin)
     && (acc_q > MAXV)) |-> (out_data == {1'b0, {(OUT_W-1){1'b1}}}));

  p_clip_neg_r2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ($past(rst_sync_n) && $past(in_valid) && $past(ctrl_clip) && !$past(ctrl_obin)
     && (acc_q < MINV)) |-> (out_data == {1'b1, {(OUT_W-1){1'b0}}}));

  p_wrap_obin_r5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ($past(rst_sync_n) && $past(in_valid) && !$past(ctrl_clip) && $past(ctrl_obin))
    |-> (out_data == {~acc_q[IN_W-1], acc_q[IN_W-2 -: OUT_W-1]}));

  p_wrap_twos_r3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ($past(rst_sync_n) && $past(in_valid) && !$past(ctrl_clip) && !$past(ctrl_obin))
    |-> (out_data == acc_q[IN_W-1 -: OUT_W]));
endmodule

bind sumfmt_top sumfmt_top_chk #(.N_CH(N_CH), .IN_W(IN_W), .OUT_W(OUT_W)) u_chk (
  .clk(clk), .rst_sync_n(rst_sync_n), .in_valid(in_valid), .in_data(in_data),
  .ctrl_clip(ctrl_clip), .ctrl_obin(ctrl_obin), .out_valid(out_valid),
  .out_data(out_data)
);

// File: tb/sumfmt_top_tb.sv
module sumfmt_top_tb;
  logic        clk;
  logic        rst_n;
  logic        cfg_we;
  logic [3:0]  cfg_addr;
  logic [7:0]  cfg_wdata;
  logic        in_valid;
  logic [71:0] in_data;
  logic        out_valid;
  logic [15:0] out_data;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  sumfmt_top u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .in_valid(in_valid), .in_data(in_data),
    .out_valid(out_valid), .out_data(out_data)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  function automatic logic [15:0] model(int s, bit clip, bit obin);
    logic [15:0] w;
    if (clip && s > 131071)       w = 16'h7FFF;
    else if (clip && s < -131072) w = 16'h8000;
    else                          w = 16'(s >>> 2);
    if (obin) w[15] = ~w[15];
    return w;
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr_cfg(logic [3:0] a, logic [7:0] d);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic put(int a, int b, int c, int d);
    in_data  = {18'(d), 18'(c), 18'(b), 18'(a)};
    in_valid = 1'b1;
  endtask

  task automatic do_reset();
    rst_n = 1'b0; in_valid = 1'b0; cfg_we = 1'b0;
    repeat (3) @(negedge clk);
    check("R10 valid in reset", 32'(out_valid), 32'd0);
    check("R10 data in reset", 32'(out_data), 32'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int vals[8] = '{-131072, -131071, -40000, -3, 0, 5, 70000, 131071};
    logic [15:0] last;
    cfg_addr = '0; cfg_wdata = '0; in_data = '0;
    do_reset();

    // R10: cleared controls give wrap + two's complement
    put(131071, 131071, 0, 0);
    @(negedge clk);
    check("R10 default mode", 32'(out_data), 32'(model(262142, 0, 0)));
    check("R6 valid follows", 32'(out_valid), 32'd1);

    for (int m = 0; m < 4; m++) begin
      in_valid = 1'b0;
      wr_cfg(4'd0, 8'(m));
      for (int i0 = 0; i0 < 8; i0++)
        for (int i1 = 0; i1 < 8; i1++)
          for (int i2 = 0; i2 < 8; i2++)
            for (int i3 = 0; i3 < 8; i3++) begin
              int s;
              string tag;
              s = vals[i0] + vals[i1] + vals[i2] + vals[i3];
              put(vals[i0], vals[i1], vals[i2], vals[i3]);
              @(negedge clk);
              if (s > 131071 || s < -131072) tag = (m[0]) ? "R2 clip" : "R3 wrap";
              else tag = "R1 sum";
              tag = {tag, (m[1]) ? " R5 offset" : " R4 twos"};
              check(tag, 32'(out_data), 32'(model(s, m[0], m[1])));
            end
    end

    // R7: hold while idle
    last = out_data;
    in_valid = 1'b0;
    in_data  = {18'd7, 18'd9, 18'd1, 18'd3};
    @(negedge clk);
    check("R7 hold data", 32'(out_data), 32'(last));
    check("R6 valid low", 32'(out_valid), 32'd0);

    // R8: write to other address ignored (mode currently clip+obin)
    wr_cfg(4'd0, 8'h00);
    wr_cfg(4'd5, 8'h03);
    put(-131072, -131072, -131072, 0);
    @(negedge clk);
    check("R8 other addr ignored", 32'(out_data), 32'(model(-393216, 0, 0)));

    // R9: write and sample on the same edge uses old mode
    cfg_we = 1'b1; cfg_addr = 4'd0; cfg_wdata = 8'h01;
    put(131071, 131071, 131071, 0);
    @(negedge clk);
    cfg_we = 1'b0;
    check("R9 same edge old mode", 32'(out_data), 32'(model(393213, 0, 0)));
    @(negedge clk);
    check("R9 next edge new mode", 32'(out_data), 32'(model(393213, 1, 0)));
    check("R2 positive rail", 32'(out_data), 32'h7FFF);

    // R10: reset mid-run clears controls
    in_valid = 1'b0;
    wr_cfg(4'd0, 8'h03);
    do_reset();
    put(-131072, -131072, 0, 0);
    @(negedge clk);
    check("R10 controls cleared", 32'(out_data), 32'(model(-262144, 0, 0)));
    in_valid = 1'b0;
    @(negedge clk);

    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule